// File: doc/BRIEF.md
# Buffered 16-bit Timer/Counter

This block is a 16-bit up-counter for a microcontroller with an 8-bit data bus. It counts either a free-running instruction tick (the system clock divided by a parameter, four by default) or rising edges of an external clock pin. The external edge can go through a two-stage synchronizer or take a shorter path that has one less stage of latency. A prescaler divides the chosen tick by 1, 2, 4 or 8 before the counter sees it. When the count wraps from all ones to zero, a sticky overflow flag is raised. An event strobe from a capture/compare unit resets the count to zero.

Software reaches the count through two byte addresses. In plain byte mode, each address reaches its half of the counter directly. In coherent 16-bit mode, a shadow register holds the upper byte. Reading the low byte captures the upper byte of the count into the shadow, so a later read of the high address returns a matching pair. Writing the high address fills only the shadow, and a later low-byte write loads all sixteen bits in one cycle.

Top module: `buffered_timer16`

## Requirements
- R1: With `cfg_src_ext` = 0, `cfg_ps` = 0 and `cfg_on` = 1, the count advances by exactly one every INST_DIV (4) clock cycles.
- R2: With `cfg_src_ext` = 1, the count advances once per rising edge of `ext_clk`. A steady high or low level, and a falling edge, do not advance it.
- R3: `cfg_ps` selects the divide ratio applied to the chosen tick: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R4: With `cfg_sync_en` = 0, an `ext_clk` level first sampled at clock edge k advances the count at edge k+1. With `cfg_sync_en` = 1, it advances the count at edge k+2.
- R5: While `cfg_on` = 0, the count and the prescaler phase hold their values.
- R6: An increment from 0xFFFF to 0x0000 sets `ovf_flag`. The flag stays set until `flag_clr` is high at a clock edge, and a new wrap in that same cycle wins over the clear.
- R7: `evt_clr` high at a clock edge makes the count 0x0000. If an increment from 0xFFFF lands in that same cycle, `ovf_flag` is still set.
- R8: With `cfg_rw16` = 1, a read strobe (`bus_rd`) at address 0 (low byte) copies the count's upper byte into the shadow. Reads at address 1 then return the shadow, even after the count has moved on.
- R9: With `cfg_rw16` = 1, a write to address 1 changes only the shadow. A write to address 0 then loads {shadow, data} into the count in one cycle.
- R10: With `cfg_rw16` = 0, address 1 reads and writes the count's upper byte directly, and address 0 reads and writes its lower byte. A write to one byte leaves the other byte unchanged.
- R11: A write that reaches the count takes priority over an increment and over `evt_clr` in the same cycle, and it restarts the prescaler from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_on | input | 1 | Counting enable |
| cfg_src_ext | input | 1 | Tick source: 0 instruction tick, 1 external edge |
| cfg_sync_en | input | 1 | 1 routes external edges through the two-stage synchronizer |
| cfg_ps | input | PS_SEL_W (2) | Prescale select, divide by 2^cfg_ps |
| cfg_rw16 | input | 1 | 1 selects coherent 16-bit access through the shadow byte |
| ext_clk | input | 1 | External count clock |
| evt_clr | input | 1 | Count reset from the capture/compare unit |
| bus_addr | input | 1 | Byte select: 0 low, 1 high |
| bus_rd | input | 1 | Read strobe (captures the shadow at address 0 in 16-bit mode) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BYTE_W (8) | Write data |
| bus_rdata | output | BYTE_W (8) | Read data for the addressed byte |
| flag_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its defaults: an 8-bit bus, a 16-bit count, an instruction divider of 4 and a two-bit prescale select. The short divider lets every prescale ratio show whole periods within a few dozen cycles. Bus writes place the count at 0xFFFE or 0xFFFF, so wrap, the clear-and-wrap collision and the write-versus-increment race each appear after a single external edge. The external source paces those races, which puts the colliding event on a clock edge the bench knows exactly.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } src_e;

  typedef enum logic {
    ADDR_LO = 1'b0,
    ADDR_HI = 1'b1
  } addr_e;
endpackage

// File: rtl/tmr16_tick_src.sv
module tmr16_tick_src
  import tmr16_pkg::*;
#(
  parameter int unsigned INST_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_i,
  input  logic src_ext_i,
  input  logic sync_en_i,
  output logic tick_o
);
  localparam int unsigned PH_W = (INST_DIV > 1) ? $clog2(INST_DIV) : 1;
  localparam int unsigned SMP_N = 3;

  logic [PH_W-1:0]  ph_q, ph_d;
  logic [SMP_N-1:0] smp_q, smp_d;
  logic             int_tick;
  logic             edge_byp;
  logic             edge_syn;
  logic             ext_tick;

  always_comb begin
    int_tick = (ph_q == PH_W'(INST_DIV - 1));
    ph_d     = int_tick ? '0 : ph_q + 1'b1;
    smp_d    = {smp_q[SMP_N-2:0], ext_clk_i};
    edge_byp = smp_q[0] & ~smp_q[1];
    edge_syn = smp_q[1] & ~smp_q[2];
    ext_tick = sync_en_i ? edge_syn : edge_byp;
    tick_o   = (src_e'(src_ext_i) == SRC_EXT) ? ext_tick : int_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      smp_q <= '0;
    end else begin
      ph_q  <= ph_d;
      smp_q <= smp_d;
    end
  end

  AST_BYPASS_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_byp |=> !edge_byp); // R2

  AST_SYNC_EDGE_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_syn |-> $past(edge_byp)); // R4

  generate
    if (INST_DIV > 1) begin : g_div_chk
      AST_INT_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        int_tick |=> !int_tick); // R1
    end
  endgenerate
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int unsigned PS_SEL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                tick_i,
  input  logic                clr_i,
  input  logic [PS_SEL_W-1:0] sel_i,
  output logic                pulse_o
);
  localparam int unsigned CNT_W = ((1 << PS_SEL_W) - 1 > 0) ? (1 << PS_SEL_W) - 1 : 1;

  logic [CNT_W-1:0] pcnt_q, pcnt_d;
  logic [CNT_W-1:0] lim;
  logic             at_lim;
  logic             adv;

  always_comb begin
    lim     = ~({CNT_W{1'b1}} << sel_i);
    at_lim  = (pcnt_q == lim);
    adv     = en_i & tick_i;
    pulse_o = adv & at_lim;
    pcnt_d  = pcnt_q;
    if (clr_i) begin
      pcnt_d = '0;
    end else if (adv) begin
      pcnt_d = at_lim ? '0 : pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

  AST_PS_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(pcnt_q)); // R5

  AST_PS_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!pulse_o || sel_i == '0)); // R11
endmodule

// File: rtl/tmr16_bus.sv
module tmr16_bus
  import tmr16_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rw16_i,
  input  logic                addr_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic [2*BYTE_W-1:0] cnt_i,
  output logic [BYTE_W-1:0]   rdata_o,
  output logic                ld_o,
  output logic [2*BYTE_W-1:0] ld_val_o
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] hbuf_q, hbuf_d;
  logic [BYTE_W-1:0] cnt_lo, cnt_hi;
  logic              lo_sel;

  always_comb begin
    cnt_lo = cnt_i[BYTE_W-1:0];
    cnt_hi = cnt_i[CNT_W-1:BYTE_W];
    lo_sel = (addr_e'(addr_i) == ADDR_LO);

    hbuf_d = hbuf_q;
    if (rw16_i && wr_i && !lo_sel) begin
      hbuf_d = wdata_i;
    end else if (rw16_i && rd_i && lo_sel) begin
      hbuf_d = cnt_hi;
    end

    ld_o = wr_i && (lo_sel || !rw16_i);
    if (lo_sel) begin
      ld_val_o = {(rw16_i ? hbuf_q : cnt_hi), wdata_i};
    end else begin
      ld_val_o = {wdata_i, cnt_lo};
    end

    if (lo_sel) begin
      rdata_o = cnt_lo;
    end else begin
      rdata_o = rw16_i ? hbuf_q : cnt_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hbuf_q <= '0;
    end else begin
      hbuf_q <= hbuf_d;
    end
  end

  AST_SHADOW_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (rw16_i && rd_i && lo_sel && !wr_i)
      |=> (!(rw16_i && !lo_sel) || rdata_o == $past(cnt_hi))); // R8

  AST_SHADOW_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rw16_i && wr_i && !lo_sel)
      |=> (!(rw16_i && !lo_sel) || rdata_o == $past(wdata_i))); // R9
endmodule

// File: rtl/buffered_timer16.sv
module buffered_timer16
  import tmr16_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned INST_DIV = 4,
  parameter int unsigned PS_SEL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_on,
  input  logic                cfg_src_ext,
  input  logic                cfg_sync_en,
  input  logic [PS_SEL_W-1:0] cfg_ps,
  input  logic                cfg_rw16,
  input  logic                ext_clk,
  input  logic                evt_clr,
  input  logic                bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  input  logic                flag_clr,
  output logic                ovf_flag
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic             tick;
  logic             ps_pulse;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             wrap;

  tmr16_tick_src #(.INST_DIV(INST_DIV)) i_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_clk_i (ext_clk),
    .src_ext_i (cfg_src_ext),
    .sync_en_i (cfg_sync_en),
    .tick_o    (tick)
  );

  tmr16_prescale #(.PS_SEL_W(PS_SEL_W)) i_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (cfg_on),
    .tick_i  (tick),
    .clr_i   (ld),
    .sel_i   (cfg_ps),
    .pulse_o (ps_pulse)
  );

  tmr16_bus #(.BYTE_W(BYTE_W)) i_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .rw16_i   (cfg_rw16),
    .addr_i   (bus_addr),
    .rd_i     (bus_rd),
    .wr_i     (bus_wr),
    .wdata_i  (bus_wdata),
    .cnt_i    (cnt_q),
    .rdata_o  (bus_rdata),
    .ld_o     (ld),
    .ld_val_o (ld_val)
  );

  always_comb begin
    wrap  = ps_pulse && (cnt_q == '1) && !ld;
    cnt_d = cnt_q;
    if (ld) begin
      cnt_d = ld_val;
    end else if (evt_clr) begin
      cnt_d = '0;
    end else if (ps_pulse) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (wrap) begin
      flag_d = 1'b1;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign ovf_flag = flag_q;

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_pulse && cnt_q == '1 && !ld) |=> ovf_flag); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag); // R6

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_on && !ld && !evt_clr) |=> $stable(cnt_q)); // R5

  AST_EVENT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !ld) |=> (cnt_q == '0)); // R7

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_val))); // R11
endmodule

// File: tb/test_buffered_timer16.sv
module test_buffered_timer16;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_on = 1'b0, cfg_src_ext = 1'b0, cfg_sync_en = 1'b0, cfg_rw16 = 1'b0;
  logic [1:0] cfg_ps = 2'd0;
  logic       ext_clk = 1'b0, evt_clr = 1'b0, flag_clr = 1'b0;
  logic       bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ovf_flag;

  buffered_timer16 i_buffered_timer16 (
    .clk(clk), .rst_n(rst_n), .cfg_on(cfg_on), .cfg_src_ext(cfg_src_ext),
    .cfg_sync_en(cfg_sync_en), .cfg_ps(cfg_ps), .cfg_rw16(cfg_rw16),
    .ext_clk(ext_clk), .evt_clr(evt_clr), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_clr(flag_clr), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    total = 0;
  int    bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int m_ph, m_s1, m_s2, m_s3, m_pc, m_cnt, m_hb, m_flag;
  int t_int, t_byp, t_syn, t_sel, t_wc, t_pl, t_old, t_ovs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_pc = 0; m_cnt = 0; m_hb = 0; m_flag = 0;
    end else begin
      t_int = (m_ph == 3) ? 1 : 0;
      m_ph  = (m_ph + 1) % 4;
      t_byp = (m_s1 == 1 && m_s2 == 0) ? 1 : 0;
      t_syn = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
      t_sel = cfg_src_ext ? (cfg_sync_en ? t_syn : t_byp) : t_int;
      t_wc  = (bus_wr && (bus_addr == 1'b0 || !cfg_rw16)) ? 1 : 0;
      t_pl  = 0;
      if (t_wc == 1) m_pc = 0;
      else if (cfg_on && t_sel == 1) begin
        if (m_pc == (1 << int'(cfg_ps)) - 1) begin t_pl = 1; m_pc = 0; end
        else m_pc = m_pc + 1;
      end
      t_old = m_cnt;
      t_ovs = (t_pl == 1 && t_wc == 0 && t_old == 'hFFFF) ? 1 : 0;
      if (t_wc == 1) begin
        if (bus_addr == 1'b0)
          m_cnt = cfg_rw16 ? ((m_hb << 8) | int'(bus_wdata)) : ((t_old & 'hFF00) | int'(bus_wdata));
        else
          m_cnt = (int'(bus_wdata) << 8) | (t_old & 'hFF);
      end else if (evt_clr) m_cnt = 0;
      else if (t_pl == 1) m_cnt = (t_old + 1) & 'hFFFF;
      if (cfg_rw16 && bus_wr && bus_addr == 1'b1) m_hb = int'(bus_wdata);
      else if (cfg_rw16 && bus_rd && bus_addr == 1'b0) m_hb = t_old >> 8;
      if (t_ovs == 1) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk ? 1 : 0;
    end
  end

  function automatic int exp_rd();
    if (bus_addr == 1'b0) return m_cnt & 'hFF;
    return cfg_rw16 ? m_hb : (m_cnt >> 8);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag, int'(ovf_flag), m_flag, "model flag");
      check(tag, int'(bus_rdata), exp_rd(), "model rdata");
    end
  end

  task automatic cycles(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic peek16(output int v);
    logic sv;
    sv = cfg_rw16;
    cfg_rw16 = 1'b0;
    bus_addr = 1'b1;
    #1 v = int'(bus_rdata) << 8;
    bus_addr = 1'b0;
    #1 v = v | int'(bus_rdata);
    cfg_rw16 = sv;
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cycles(1);
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1; cycles(2);
    ext_clk = 1'b0; cycles(2);
  endtask

  int a, b;

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // reset state
    peek16(a);
    check("R1", a, 0, "count after reset");
    check("R6", int'(ovf_flag), 0, "flag after reset");

    // R1 internal tick rate
    tag = "R1";
    cfg_on = 1'b1;
    cycles(3);
    peek16(a); cycles(8); peek16(b);
    check("R1", b - a, 2, "advance over 8 clocks");

    // R3 prescale ratios
    tag = "R3";
    for (int p = 1; p < 4; p++) begin
      cfg_on = 1'b0;
      cfg_ps = 2'(p);
      bus_write(1'b0, 8'h00);
      cfg_on = 1'b1;
      peek16(a); cycles(8 * (1 << p)); peek16(b);
      check("R3", b - a, 2, $sformatf("advance for select %0d", p));
    end

    // R5 hold while off
    tag = "R5";
    cfg_on = 1'b0;
    peek16(a); cycles(30); peek16(b);
    check("R5", b, a, "count held while off");

    // R2 external edges
    tag = "R2";
    cfg_src_ext = 1'b1; cfg_sync_en = 1'b0; cfg_ps = 2'd0;
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'h00);
    cfg_on = 1'b1;
    for (int i = 0; i < 5; i++) ext_pulse();
    peek16(a);
    check("R2", a, 5, "five rising edges");
    ext_clk = 1'b1; cycles(10); ext_clk = 1'b0; cycles(4);
    peek16(a);
    check("R2", a, 6, "long high level counts once");

    // R4 latency of both paths
    tag = "R4";
    ext_clk = 1'b1; cycles(1);
    peek16(a); check("R4", a, 6, "bypass not yet counted");
    cycles(1);
    peek16(a); check("R4", a, 7, "bypass counted one edge later");
    ext_clk = 1'b0; cycles(3);
    cfg_sync_en = 1'b1;
    ext_clk = 1'b1; cycles(2);
    peek16(a); check("R4", a, 7, "synchronized not yet counted");
    cycles(1);
    peek16(a); check("R4", a, 8, "synchronized counted two edges later");
    ext_clk = 1'b0; cycles(3);
    cfg_sync_en = 1'b0;

    // R6 wrap and sticky flag
    tag = "R6";
    cfg_on = 1'b0; cfg_rw16 = 1'b1;
    bus_write(1'b1, 8'hFF);
    bus_write(1'b0, 8'hFE);
    cfg_on = 1'b1;
    ext_pulse();
    peek16(a); check("R6", a, 'hFFFF, "count before wrap");
    check("R6", int'(ovf_flag), 0, "flag before wrap");
    ext_pulse();
    peek16(a); check("R6", a, 0, "count after wrap");
    check("R6", int'(ovf_flag), 1, "flag after wrap");
    cycles(5);
    check("R6", int'(ovf_flag), 1, "flag stays set");
    flag_clr = 1'b1; cycles(1); flag_clr = 1'b0;
    check("R6", int'(ovf_flag), 0, "flag cleared");

    // R7 event clear, alone and with a wrap
    tag = "R7";
    ext_pulse();
    evt_clr = 1'b1; cycles(1); evt_clr = 1'b0;
    peek16(a); check("R7", a, 0, "event clears count");
    cfg_on = 1'b0;
    bus_write(1'b1, 8'hFF);
    bus_write(1'b0, 8'hFF);
    cfg_on = 1'b1;
    ext_clk = 1'b1; cycles(1);
    evt_clr = 1'b1; cycles(1); evt_clr = 1'b0;
    peek16(a); check("R7", a, 0, "clear wins with wrap");
    check("R7", int'(ovf_flag), 1, "wrap flag set during clear");
    ext_clk = 1'b0; cycles(3);
    flag_clr = 1'b1; cycles(1); flag_clr = 1'b0;

    // R8 coherent read
    tag = "R8";
    cfg_on = 1'b0;
    bus_write(1'b1, 8'h12);
    bus_write(1'b0, 8'hFF);
    cfg_on = 1'b1;
    bus_addr = 1'b0; bus_rd = 1'b1; cycles(1); bus_rd = 1'b0;
    ext_pulse();
    bus_addr = 1'b1; #1;
    check("R8", int'(bus_rdata), 'h12, "high read returns captured byte");
    bus_addr = 1'b0;
    peek16(a); check("R8", a, 'h1300, "count moved on");

    // R9 coherent write
    tag = "R9";
    cfg_on = 1'b0;
    bus_write(1'b1, 8'hAB);
    peek16(a); check("R9", a, 'h1300, "high write leaves count");
    bus_addr = 1'b1; #1;
    check("R9", int'(bus_rdata), 'hAB, "shadow holds written byte");
    bus_addr = 1'b0;
    bus_write(1'b0, 8'hCD);
    peek16(a); check("R9", a, 'hABCD, "low write loads both bytes");

    // R10 byte mode
    tag = "R10";
    cfg_rw16 = 1'b0;
    bus_write(1'b1, 8'h5A);
    peek16(a); check("R10", a, 'h5ACD, "direct high write");
    bus_addr = 1'b1; #1;
    check("R10", int'(bus_rdata), 'h5A, "direct high read");
    bus_addr = 1'b0;
    bus_write(1'b0, 8'h11);
    peek16(a); check("R10", a, 'h5A11, "direct low write");

    // R11 write priority and prescaler restart
    tag = "R11";
    cfg_on = 1'b1;
    ext_clk = 1'b1; cycles(1);
    bus_write(1'b0, 8'h77);
    peek16(a); check("R11", a, 'h5A77, "write beats increment");
    ext_clk = 1'b0; cycles(3);
    cfg_ps = 2'd1;
    ext_pulse();
    peek16(a); check("R11", a, 'h5A77, "half of divide-by-two");
    bus_write(1'b0, 8'h20);
    ext_pulse();
    peek16(a); check("R11", a, 'h5A20, "prescaler restarted by write");
    ext_pulse();
    peek16(a); check("R11", a, 'h5A21, "second edge completes ratio");
    evt_clr = 1'b1;
    bus_write(1'b0, 8'h30);
    evt_clr = 1'b0;
    peek16(a); check("R11", a, 'h5A30, "write beats event clear");

    cycles(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule